// File: doc/BRIEF.md
# Mapped Interrupt Controller

This block gathers 64 interrupt sources and steers each one onto one of eight CPU interrupt lines. A source counts as active when any of three things is true: its raw request input is high, software has set its bit in the diagnostic register, or a message interrupt has latched its bit in the pending register. Active sources pass through a mask. A 3-bit map register for each source then picks the output line it drives.

Software reaches the diagnostic, mask, trace-enable and map registers through one address/data port, and it can read back the pending register there. A separate message port takes a vector number and latches the matching pending bit. A write-one-to-clear port removes pending bits. The per-output status, the raw source status and the trace trigger are all registered, so every output follows its inputs by one clock.

Top module: `irq_map_ctrl`

## Requirements
- R1: After reset the mask register reads all ones. The diagnostic, trace-enable, pending and map registers read zero, and `irq_o` and `trace_o` are 0.
- R2: An unmasked source whose raw request is high drives `irq_o[n]` high, where n is the value in that source's map register.
- R3: Writing 1 to bit i of the diagnostic register (address 0) makes source i active. It stays active until software writes that bit back to 0.
- R4: A message write with a vector v in 0..63 sets pending bit v. The pending register reads back at address 3, and a set pending bit makes its source active.
- R5: A message write with a vector of 64 or more changes no pending bit.
- R6: A clear write clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R7: When a message set and a clear hit the same pending bit in the same cycle, the bit ends up set.
- R8: While mask bit i (address 1) is 1, source i drives no output line and no status bit. `src_stat_o[i]` still shows 1 while the source is active.
- R9: `stat_o` returns the status of output `stat_sel_i`. Bit i of that status is 1 only when source i is active, unmasked, and its map register (address 64+i, low 3 bits) equals `stat_sel_i`. The status of every other output keeps bit i at 0.
- R10: `trace_o` is 1 one clock after any active source has its trace-enable bit set (address 2). This holds whatever the mask.
- R11: Status, `irq_o`, `src_stat_o` and `trace_o` change exactly one clock edge after the active, mask or map values that produce them. They do not change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 64 | Raw request per source |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register address: 0 diag, 1 mask, 2 trace, 3 pending (read only), 64+i map i |
| reg_wdata_i | input | 64 | Register write data |
| reg_rdata_o | output | 64 | Register read data for reg_addr_i |
| msg_wr_i | input | 1 | Message interrupt strobe |
| msg_vec_i | input | 8 | Message vector number |
| clr_wr_i | input | 1 | Pending clear strobe |
| clr_data_i | input | 64 | Pending clear bits, one clears |
| stat_sel_i | input | 3 | Output whose status is shown |
| stat_o | output | 64 | Status of the selected output |
| src_stat_o | output | 64 | Active sources regardless of mask |
| irq_o | output | 8 | CPU interrupt lines |
| trace_o | output | 1 | Trace trigger |

## Verification
The hardest case to reach from the ports is a message set and a clear that land on the same pending bit in one cycle. It needs both strobes raised together, with the clear data also covering other bits, so that the set-wins rule and the ordinary clear show up in a single readback. The bench first latches bits through separate message writes. It then drives one combined cycle and reads the pending register at address 3. The stimulus also aims out-of-range vectors at a register that already holds pending bits, so that a stray set would be visible.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  // Low two address bits select a word register when the map bit is clear
  typedef enum logic [1:0] {
    SEL_DIAG  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_TRACE = 2'd2,
    SEL_PEND  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_map_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int NUM_OUT = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int MAP_W  = $clog2(NUM_OUT),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [NUM_SRC-1:0]               wdata,
  input  logic [NUM_SRC-1:0]               pend_i,
  output logic [NUM_SRC-1:0]               rdata,
  output logic [NUM_SRC-1:0]               diag_o,
  output logic [NUM_SRC-1:0]               mask_o,
  output logic [NUM_SRC-1:0]               trace_en_o,
  output logic [NUM_SRC-1:0][MAP_W-1:0]    map_o
);

  logic [NUM_SRC-1:0]            diag_q, diag_d;
  logic [NUM_SRC-1:0]            mask_q, mask_d;
  logic [NUM_SRC-1:0]            trace_q, trace_d;
  logic [NUM_SRC-1:0][MAP_W-1:0] map_q, map_d;
  logic                          is_map;
  logic [IDX_W-1:0]              map_idx;

  assign is_map  = addr[IDX_W];
  assign map_idx = addr[IDX_W-1:0];

  always_comb begin
    diag_d  = diag_q;
    mask_d  = mask_q;
    trace_d = trace_q;
    map_d   = map_q;
    if (is_map) begin
      map_d[map_idx] = wdata[MAP_W-1:0];
    end else begin
      case (reg_sel_e'(addr[1:0]))
        SEL_DIAG:  diag_d  = wdata;
        SEL_MASK:  mask_d  = wdata;
        SEL_TRACE: trace_d = wdata;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      diag_q  <= '0;
      mask_q  <= '1;
      trace_q <= '0;
      map_q   <= '0;
    end else if (wr_en) begin
      diag_q  <= diag_d;
      mask_q  <= mask_d;
      trace_q <= trace_d;
      map_q   <= map_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (is_map) begin
      rdata[MAP_W-1:0] = map_q[map_idx];
    end else begin
      case (reg_sel_e'(addr[1:0]))
        SEL_DIAG:  rdata = diag_q;
        SEL_MASK:  rdata = mask_q;
        SEL_TRACE: rdata = trace_q;
        default:   rdata = pend_i;
      endcase
    end
  end

  assign diag_o     = diag_q;
  assign mask_o     = mask_q;
  assign trace_en_o = trace_q;
  assign map_o      = map_q;

  AST_DIAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !is_map && addr[1:0] == SEL_DIAG) |=> $stable(diag_q)); // R3

endmodule

// File: rtl/irq_msg_latch.sv
module irq_msg_latch #(
  parameter int NUM_SRC = 64,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_wr,
  input  logic [VEC_W-1:0]   msg_vec,
  input  logic               clr_wr,
  input  logic [NUM_SRC-1:0] clr_data,
  output logic [NUM_SRC-1:0] pend_o
);

  logic [NUM_SRC-1:0] pend_q, pend_d;
  logic               in_range;
  logic               upd;

  assign in_range = (msg_vec >> IDX_W) == '0;
  assign upd      = msg_wr | clr_wr;

  always_comb begin
    pend_d = pend_q;
    if (clr_wr) pend_d = pend_d & ~clr_data;
    if (msg_wr && in_range) pend_d[msg_vec[IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_VEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_wr && !in_range && !clr_wr) |=> $stable(pend_q)); // R5
  AST_CLR_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !msg_wr) |=> (pend_q & $past(clr_data)) == '0); // R6
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_wr && in_range) |=> pend_q[$past(msg_vec[IDX_W-1:0])]); // R7

endmodule

// File: rtl/irq_route.sv
module irq_route #(
  parameter int NUM_SRC = 64,
  parameter int NUM_OUT = 8,
  localparam int MAP_W  = $clog2(NUM_OUT)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_SRC-1:0]               active_i,
  input  logic [NUM_SRC-1:0]               mask_i,
  input  logic [NUM_SRC-1:0]               trace_en_i,
  input  logic [NUM_SRC-1:0][MAP_W-1:0]    map_i,
  output logic [NUM_OUT-1:0][NUM_SRC-1:0]  status_o,
  output logic [NUM_SRC-1:0]               src_stat_o,
  output logic [NUM_OUT-1:0]               irq_o,
  output logic                             trace_o
);

  logic [NUM_OUT-1:0][NUM_SRC-1:0] hit;
  logic [NUM_OUT-1:0][NUM_SRC-1:0] status_d, status_q;
  logic [NUM_SRC-1:0]              src_stat_q;
  logic                            trace_d, trace_q;

  for (genvar n = 0; n < NUM_OUT; n++) begin : g_out
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      assign hit[n][i] = (map_i[i] == MAP_W'(n));
    end
    assign status_d[n] = active_i & ~mask_i & hit[n];
    assign irq_o[n]    = |status_q[n];

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[n] & $past(mask_i)) == '0); // R8
  end

  assign trace_d = |(active_i & trace_en_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q   <= '0;
      src_stat_q <= '0;
      trace_q    <= 1'b0;
    end else begin
      status_q   <= status_d;
      src_stat_q <= active_i;
      trace_q    <= trace_d;
    end
  end

  assign status_o   = status_q;
  assign src_stat_o = src_stat_q;
  assign trace_o    = trace_q;

endmodule

// File: rtl/irq_map_ctrl.sv
module irq_map_ctrl #(
  parameter int NUM_SRC = 64,
  parameter int NUM_OUT = 8,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int MAP_W  = $clog2(NUM_OUT),
  localparam int ADDR_W = IDX_W + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_req_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [NUM_SRC-1:0] reg_wdata_i,
  output logic [NUM_SRC-1:0] reg_rdata_o,
  input  logic               msg_wr_i,
  input  logic [VEC_W-1:0]   msg_vec_i,
  input  logic               clr_wr_i,
  input  logic [NUM_SRC-1:0] clr_data_i,
  input  logic [MAP_W-1:0]   stat_sel_i,
  output logic [NUM_SRC-1:0] stat_o,
  output logic [NUM_SRC-1:0] src_stat_o,
  output logic [NUM_OUT-1:0] irq_o,
  output logic               trace_o
);

  logic [1:0]                      rst_sync_q;
  logic                            rst_int_n;
  logic [NUM_SRC-1:0]              diag, mask, trace_en, pend, active;
  logic [NUM_SRC-1:0][MAP_W-1:0]   map;
  logic [NUM_OUT-1:0][NUM_SRC-1:0] status;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .wr_en      (reg_wr_i),
    .addr       (reg_addr_i),
    .wdata      (reg_wdata_i),
    .pend_i     (pend),
    .rdata      (reg_rdata_o),
    .diag_o     (diag),
    .mask_o     (mask),
    .trace_en_o (trace_en),
    .map_o      (map)
  );

  irq_msg_latch #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_msg (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .msg_wr   (msg_wr_i),
    .msg_vec  (msg_vec_i),
    .clr_wr   (clr_wr_i),
    .clr_data (clr_data_i),
    .pend_o   (pend)
  );

  assign active = src_req_i | diag | pend;

  irq_route #(.NUM_SRC(NUM_SRC), .NUM_OUT(NUM_OUT)) u_route (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .active_i   (active),
    .mask_i     (mask),
    .trace_en_i (trace_en),
    .map_i      (map),
    .status_o   (status),
    .src_stat_o (src_stat_o),
    .irq_o      (irq_o),
    .trace_o    (trace_o)
  );

  assign stat_o = status[stat_sel_i];

  AST_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (|irq_o) |-> (|($past(active) & ~$past(mask)))); // R11
  AST_SRC_STAT_LAG: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(rst_int_n) || (src_stat_o == $past(src_req_i | diag | pend))); // R11

endmodule

// File: tb/irq_map_ctrl_tb.sv
module irq_map_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] src_req;
  logic        reg_wr;
  logic [6:0]  reg_addr;
  logic [63:0] reg_wdata, reg_rdata;
  logic        msg_wr;
  logic [7:0]  msg_vec;
  logic        clr_wr;
  logic [63:0] clr_data;
  logic [2:0]  stat_sel;
  logic [63:0] stat, src_stat;
  logic [7:0]  irq;
  logic        trace;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_map_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .msg_wr_i(msg_wr), .msg_vec_i(msg_vec),
    .clr_wr_i(clr_wr), .clr_data_i(clr_data), .stat_sel_i(stat_sel),
    .stat_o(stat), .src_stat_o(src_stat), .irq_o(irq), .trace_o(trace)
  );

  // {source[8:3], output[2:0]}
  localparam logic [8:0] ROUTE_TBL [6] = '{
    {6'd0, 3'd0}, {6'd63, 3'd7}, {6'd17, 3'd3},
    {6'd40, 3'd5}, {6'd9, 3'd1}, {6'd33, 3'd6}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr_reg(input logic [6:0] a, input logic [63:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [6:0] a, output logic [63:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send_msg(input logic [7:0] v);
    msg_wr = 1'b1; msg_vec = v;
    step();
    msg_wr = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] rd;
    rst_n = 1'b0; src_req = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    msg_wr = 1'b0; msg_vec = '0; clr_wr = 1'b0; clr_data = '0; stat_sel = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rd_reg(7'd1, rd);  chk("R1 mask", rd, '1);
    rd_reg(7'd0, rd);  chk("R1 diag", rd, '0);
    rd_reg(7'd2, rd);  chk("R1 trace", rd, '0);
    rd_reg(7'd3, rd);  chk("R1 pend", rd, '0);
    rd_reg(7'd69, rd); chk("R1 map5", rd, '0);
    chk("R1 irq", {56'd0, irq}, '0);
    chk("R1 trace_o", {63'd0, trace}, '0);

    wr_reg(7'd1, '0); // unmask all

    // R2 / R9 / R11 table walk
    for (int k = 0; k < 6; k++) begin
      int s; int o;
      s = int'(ROUTE_TBL[k][8:3]);
      o = int'(ROUTE_TBL[k][2:0]);
      wr_reg(7'd64 + 7'(s), 64'(o));
      rd_reg(7'd64 + 7'(s), rd); chk("R9 map readback", rd, 64'(o));
      src_req[s] = 1'b1; #1;
      chk("R11 no same-cycle irq", {56'd0, irq}, '0);
      step();
      chk("R2 irq line", {56'd0, irq}, 64'(8'(1) << o));
      chk("R11 src_stat", src_stat, 64'(1) << s);
      stat_sel = 3'(o); #1;
      chk("R9 status sel", stat, 64'(1) << s);
      stat_sel = 3'(o + 1); #1;
      chk("R9 status other", stat, '0);
      src_req[s] = 1'b0;
      step();
      chk("R2 irq drop", {56'd0, irq}, '0);
    end

    // R8 mask gates output, not source status (source 17 -> out 3)
    wr_reg(7'd1, 64'(1) << 17);
    src_req[17] = 1'b1;
    step();
    chk("R8 masked irq", {56'd0, irq}, '0);
    chk("R8 src_stat", src_stat, 64'(1) << 17);
    stat_sel = 3'd3; #1; chk("R8 status", stat, '0);
    src_req[17] = 1'b0;
    wr_reg(7'd1, '0);

    // R3 diagnostic set holds (source 40 -> out 5)
    wr_reg(7'd0, 64'(1) << 40);
    step();
    chk("R3 diag raise", {56'd0, irq}, 64'h20);
    repeat (3) step();
    chk("R3 diag hold", {56'd0, irq}, 64'h20);
    wr_reg(7'd0, '0);
    step();
    chk("R3 diag clear", {56'd0, irq}, '0);

    // R4 message set (source 9 -> out 1)
    send_msg(8'd9);
    rd_reg(7'd3, rd); chk("R4 pend readback", rd, 64'(1) << 9);
    step();
    chk("R4 msg irq", {56'd0, irq}, 64'h02);

    // R6 write-one-to-clear
    send_msg(8'd0);
    clr_wr = 1'b1; clr_data = (64'(1) << 9) | (64'(1) << 50);
    step(); clr_wr = 1'b0;
    rd_reg(7'd3, rd); chk("R6 clear ones only", rd, 64'(1));

    // R7 set beats clear on same bit
    msg_wr = 1'b1; msg_vec = 8'd12;
    clr_wr = 1'b1; clr_data = (64'(1) << 12) | 64'(1);
    step(); msg_wr = 1'b0; clr_wr = 1'b0;
    rd_reg(7'd3, rd); chk("R7 set wins", rd, 64'(1) << 12);

    // R5 out-of-range vectors
    send_msg(8'd64);
    send_msg(8'd200);
    rd_reg(7'd3, rd); chk("R5 vec ignored", rd, 64'(1) << 12);
    clr_wr = 1'b1; clr_data = '1; step(); clr_wr = 1'b0;
    step();

    // R10 trace regardless of mask (source 20)
    wr_reg(7'd2, 64'(1) << 20);
    wr_reg(7'd1, 64'(1) << 20);
    src_req[20] = 1'b1; #1;
    chk("R11 trace latency", {63'd0, trace}, '0);
    step();
    chk("R10 trace on", {63'd0, trace}, 64'd1);
    chk("R10 masked irq", {56'd0, irq}, '0);
    wr_reg(7'd2, '0);
    step();
    chk("R10 trace off", {63'd0, trace}, '0);
    src_req = '0;

    summary();
    $finish;
  end

endmodule